// File: doc/BRIEF.md
# Memory-Table DMA Channel Engine

This block is a small multi-channel DMA engine that keeps no per-channel transfer setup inside itself. Every channel owns a 16-byte descriptor slot in a control table held in ordinary system memory. The table starts at a 1 KiB-aligned base address. When an enabled channel raises its request line, the engine works out where that channel's slot lives. It fetches the three live words of the slot: the last source address, the last destination address and the control word. It then moves exactly one 32-bit data word and writes the control word back with the count of items still to go.

The two pointer words name the final address of each side, inclusive. The address of the current item is therefore found by stepping backwards from that pointer by the number of items still to go after it. A side that does not advance keeps the pointer itself as its fixed address. When the last item has been written, the control word shows a zero count and the stopped mode. The engine also clears the channel's enable bit and pulses a per-channel done line. Each channel also has a selector that makes the engine use its slot in the upper half of the table instead of the lower half.

A small register port sets the table base, sets and clears enable bits, and sets the upper-half selectors. The memory master port issues one access per cycle. Read data arrives in the cycle after a read request.

Top module: `dte_engine`

## Requirements
- R1: The table base register (register select 0) stores bits [31:10] of the written value. Bits [9:0] always read as zero.
- R2: The slot of channel n in the lower half is at base + n*16. The engine reads slot word +0x0 (last source address), then +0x4 (last destination address), then +0x8 (control word) on consecutive cycles. It never accesses +0xC.
- R3: If bit n of the half-select register (register select 3) is 1, the slot of channel n is at base + 0x200 + n*16.
- R4: Control word fields are: mode in bits [1:0] (00 stopped, anything else active), count-minus-one in bits [13:4], source step code in bits [25:24], and destination step code in bits [31:30]. Step codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = no step. The item address on each side is the last address minus (count-minus-one field) times that side's step.
- R5: Each service moves one word. The word read from the source item address is written unchanged to the destination item address.
- R6: After each item, the engine writes the control word back to slot +0x8 with bits [31:14] and [3:2] unchanged. If the count-minus-one field was nonzero, that field is decremented and the mode is kept. If it was zero, the field becomes 0 and the mode becomes 00. Slot words +0x0 and +0x4 are never written.
- R7: Writing to register select 1 sets the enable bits that are 1 in the data. Writing to register select 2 clears them. Zero data bits leave the enables unchanged. Reading either select returns the enable bits.
- R8: After the final item of a channel, its enable bit reads 0 with no register access.
- R9: A request on a channel whose enable bit is 0 causes no memory access.
- R10: When several enabled channels request at once, the lowest-numbered one is served first.
- R11: `done[n]` is high for exactly the cycle in which the final control-word write of channel n is issued.
- R12: If the fetched control word has mode 00, the engine moves no data and writes nothing. It clears the channel's enable bit and raises no done.
- R13: After reset the base, enable and half-select registers are zero and no memory access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 enable set, 2 enable clear, 3 half select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dreq | input | NCH | Per-channel service request, level |
| done | output | NCH | Per-channel completion pulse |
| mem_req | output | 1 | Memory access valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The main function is tried with five descriptor patterns:
- a four-item word-to-word copy;
- a byte-stepping source feeding a fixed destination;
- a two-item halfword copy from an upper-half slot;
- two single-item channels requested together;
- a slot whose control word is already stopped.

The word copy separates correct pointer arithmetic from an off-by-one in the backwards step. The byte/fixed pair exposes a swapped or mis-decoded step code, because only the last source byte survives at the fixed destination. The upper-half slot leaves a stopped primary slot behind, so a half-select fault moves nothing. The simultaneous pair separates the arbitration order. The stopped slot tells a mode check apart from blind copying.

// File: rtl/dte_pkg.sv
package dte_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned CNT_W       = 10;
    localparam int unsigned ENTRY_SHIFT = 4;
    localparam logic [31:0] HALF_OFFSET = 32'h0000_0200;
    localparam logic [31:0] BASE_MASK   = 32'hFFFF_FC00;
    localparam logic [1:0]  MODE_STOP   = 2'b00;

    // slot word offsets
    localparam logic [31:0] OFS_SRC = 32'h0;
    localparam logic [31:0] OFS_DST = 32'h4;
    localparam logic [31:0] OFS_CTL = 32'h8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RSRC,
        PH_RDST,
        PH_RCTL,
        PH_CALC,
        PH_RDAT,
        PH_WDAT,
        PH_WCTL
    } phase_e;

    typedef enum logic [1:0] {
        RS_BASE  = 2'd0,
        RS_ENSET = 2'd1,
        RS_ENCLR = 2'd2,
        RS_HALF  = 2'd3
    } regsel_e;

endpackage

// File: rtl/dte_chan_regs.sv
module dte_chan_regs
    import dte_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic [NCH-1:0]  auto_clr,
    output logic [NCH-1:0]  en,
    output logic [NCH-1:0]  half_sel,
    output logic [31:0]     base,
    output logic [31:0]     rdata
);

    typedef struct packed {
        logic [31:0]    base;
        logic [NCH-1:0] en;
        logic [NCH-1:0] half;
    } regs_t;

    regs_t r_d, r_q;
    logic [NCH-1:0] set_bits, clr_bits;

    always_comb begin
        r_d      = r_q;
        set_bits = '0;
        clr_bits = '0;
        if (reg_wr) begin
            case (reg_addr)
                RS_BASE:  r_d.base = reg_wdata & BASE_MASK;
                RS_ENSET: set_bits = reg_wdata[NCH-1:0];
                RS_ENCLR: clr_bits = reg_wdata[NCH-1:0];
                default:  r_d.half = reg_wdata[NCH-1:0];
            endcase
        end
        // software set wins over a same-cycle clear
        r_d.en = (r_q.en & ~clr_bits & ~auto_clr) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            RS_BASE:  rdata = r_q.base;
            RS_ENSET: rdata = 32'(r_q.en);
            RS_ENCLR: rdata = 32'(r_q.en);
            default:  rdata = 32'(r_q.half);
        endcase
    end

    assign en       = r_q.en;
    assign half_sel = r_q.half;
    assign base     = r_q.base;

    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RS_ENSET) |=>
        ((r_q.en & $past(reg_wdata[NCH-1:0])) == $past(reg_wdata[NCH-1:0])));

endmodule

// File: rtl/dte_prio_arb.sv
module dte_prio_arb #(
    parameter  int unsigned NCH = 8,
    localparam int unsigned CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CW-1:0]  idx
);

    logic [NCH-1:0] masked;
    logic [NCH-1:0] gnt;

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_lane
            if (i == 0) begin : g_head
                assign masked[i] = 1'b0;
            end else begin : g_tail
                assign masked[i] = masked[i-1] | req[i-1];
            end
            assign gnt[i] = req[i] & ~masked[i];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = 0; k < NCH; k++) begin
            if (gnt[k]) idx = CW'(k);
        end
    end

    assign any = |req;

endmodule

// File: rtl/dte_addr_calc.sv
module dte_addr_calc
    import dte_pkg::*;
(
    input  logic [31:0]      last_ptr,
    input  logic [CNT_W-1:0] left,
    input  logic [1:0]       step_code,
    output logic [31:0]      addr
);

    logic [31:0] span;

    always_comb begin
        case (step_code)
            2'd0:    span = 32'(left);
            2'd1:    span = 32'(left) << 1;
            2'd2:    span = 32'(left) << 2;
            default: span = '0;
        endcase
        addr = last_ptr - span;
    end

endmodule

// File: rtl/dte_engine.sv
module dte_engine
    import dte_pkg::*;
#(
    parameter  int unsigned NCH = 8,
    localparam int unsigned CW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NCH-1:0]  dreq,
    output logic [NCH-1:0]  done,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata
);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] ch;
        logic [31:0]   src_last;
        logic [31:0]   dst_last;
        logic [31:0]   ctl;
        logic [31:0]   src_addr;
        logic [31:0]   dst_addr;
    } seq_t;

    seq_t st_d, st_q;

    logic [NCH-1:0] en, half_sel, auto_clr, live_req, ch_bit;
    logic [31:0]    base, slot, ctl_next, src_item, dst_item;
    logic           arb_any, last_item;
    logic [CW-1:0]  arb_idx;

    dte_chan_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .auto_clr (auto_clr),
        .en       (en),
        .half_sel (half_sel),
        .base     (base),
        .rdata    (reg_rdata)
    );

    assign live_req = dreq & en;

    dte_prio_arb #(.NCH(NCH)) u_arb (
        .req(live_req),
        .any(arb_any),
        .idx(arb_idx)
    );

    dte_addr_calc u_src_calc (
        .last_ptr (st_q.src_last),
        .left     (mem_rdata[13:4]),
        .step_code(mem_rdata[25:24]),
        .addr     (src_item)
    );

    dte_addr_calc u_dst_calc (
        .last_ptr (st_q.dst_last),
        .left     (mem_rdata[13:4]),
        .step_code(mem_rdata[31:30]),
        .addr     (dst_item)
    );

    assign slot = base + (half_sel[st_q.ch] ? HALF_OFFSET : 32'h0)
                + (32'(st_q.ch) << ENTRY_SHIFT);
    assign ch_bit    = NCH'(1) << st_q.ch;
    assign last_item = (st_q.ctl[13:4] == '0);
    assign ctl_next  = last_item
        ? {st_q.ctl[31:14], {CNT_W{1'b0}}, st_q.ctl[3:2], MODE_STOP}
        : {st_q.ctl[31:14], st_q.ctl[13:4] - 10'd1, st_q.ctl[3:0]};

    always_comb begin
        st_d      = st_q;
        auto_clr  = '0;
        done      = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st_q.ph)
            PH_IDLE: begin
                if (arb_any) begin
                    st_d.ch = arb_idx;
                    st_d.ph = PH_RSRC;
                end
            end
            PH_RSRC: begin
                mem_req  = 1'b1;
                mem_addr = slot + OFS_SRC;
                st_d.ph  = PH_RDST;
            end
            PH_RDST: begin
                mem_req       = 1'b1;
                mem_addr      = slot + OFS_DST;
                st_d.src_last = mem_rdata;
                st_d.ph       = PH_RCTL;
            end
            PH_RCTL: begin
                mem_req       = 1'b1;
                mem_addr      = slot + OFS_CTL;
                st_d.dst_last = mem_rdata;
                st_d.ph       = PH_CALC;
            end
            PH_CALC: begin
                st_d.ctl      = mem_rdata;
                st_d.src_addr = src_item;
                st_d.dst_addr = dst_item;
                if (mem_rdata[1:0] == MODE_STOP) begin
                    auto_clr = ch_bit;
                    st_d.ph  = PH_IDLE;
                end else begin
                    st_d.ph  = PH_RDAT;
                end
            end
            PH_RDAT: begin
                mem_req  = 1'b1;
                mem_addr = st_q.src_addr;
                st_d.ph  = PH_WDAT;
            end
            PH_WDAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = st_q.dst_addr;
                mem_wdata = mem_rdata;
                st_d.ph   = PH_WCTL;
            end
            PH_WCTL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot + OFS_CTL;
                mem_wdata = ctl_next;
                if (last_item) begin
                    auto_clr = ch_bit;
                    done     = ch_bit;
                end
                st_d.ph   = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && (dreq & en) == '0) |=> st_q.ph == PH_IDLE);

    // R10
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && arb_any) |=>
        (($past(dreq & en) & ((NCH'(1) << st_q.ch) - NCH'(1))) == '0));

    // R6
    ctl_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st_q.ph == PH_WCTL) |->
        (mem_addr[3:0] == 4'h8 && mem_wdata[31:14] == st_q.ctl[31:14]));

    // R11
    done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> ($onehot(done) && mem_we && mem_addr[3:0] == 4'h8));

    // R8
    auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done) && !(reg_wr && reg_addr == RS_ENSET)) |=>
        ((en & $past(done)) == '0));

endmodule

// File: tb/sim_dte_engine.sv
`timescale 1ns/1ps
module sim_dte_engine;

    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  dreq = '0;
    logic [NCH-1:0]  done;
    logic            mem_req, mem_we;
    logic [31:0]     mem_addr, mem_wdata;
    logic [31:0]     mem_rdata = '0;

    always #4 clk = ~clk;

    dte_engine #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // ---------------- memory ----------------
    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
        else if (mem_req)      mem_rdata <= rd(mem_addr);
    end

    // ---------------- reference model ----------------
    int             m_ph = 0;
    int             m_ch = 0;
    logic [31:0]    m_base = '0;
    logic [NCH-1:0] m_en = '0, m_half = '0, m_clr, m_set, m_sclr;
    logic [31:0]    m_ctl = '0, m_sa = '0, m_da = '0, m_dat = '0;

    function automatic logic [31:0] m_slot();
        return m_base + (m_half[m_ch] ? 32'h200 : 32'h0) + 32'(m_ch) * 32'd16;
    endfunction

    function automatic logic [31:0] step(input logic [1:0] c);
        case (c)
            2'd0: return 32'd1;
            2'd1: return 32'd2;
            2'd2: return 32'd4;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_ch = 0; m_base = '0; m_en = '0; m_half = '0;
        end else begin
            m_clr = '0; m_set = '0; m_sclr = '0;
            case (m_ph)
                0: if ((dreq & m_en) != '0) begin
                    for (int k = NCH - 1; k >= 0; k--)
                        if (dreq[k] && m_en[k]) m_ch = k;
                    m_ph = 1;
                end
                1, 2, 3: m_ph = m_ph + 1;
                4: begin
                    m_ctl = rd(m_slot() + 32'h8);
                    if (m_ctl[1:0] == 2'b00) begin
                        m_clr[m_ch] = 1'b1;
                        m_ph = 0;
                    end else begin
                        m_sa = rd(m_slot()) - 32'(m_ctl[13:4]) * step(m_ctl[25:24]);
                        m_da = rd(m_slot() + 32'h4) - 32'(m_ctl[13:4]) * step(m_ctl[31:30]);
                        m_ph = 5;
                    end
                end
                5: begin m_dat = rd(m_sa); m_ph = 6; end
                6: m_ph = 7;
                default: begin
                    if (m_ctl[13:4] == 10'd0) m_clr[m_ch] = 1'b1;
                    m_ph = 0;
                end
            endcase
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_base = reg_wdata & 32'hFFFF_FC00;
                    2'd1: m_set  = reg_wdata[NCH-1:0];
                    2'd2: m_sclr = reg_wdata[NCH-1:0];
                    default: m_half = reg_wdata[NCH-1:0];
                endcase
            end
            m_en = (m_en & ~m_clr & ~m_sclr) | m_set;
        end
    end

    // per-cycle comparison, away from the active edge
    int req_cycles = 0;
    int first_done = -1;
    int done7_seen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic        e_req, e_we;
            logic [31:0] e_addr, e_wd;
            logic [NCH-1:0] e_done;
            string       atag;
            e_req = 1'b0; e_we = 1'b0; e_addr = '0; e_wd = '0; e_done = '0;
            atag = m_half[m_ch] ? "R3 slot address" : "R2 slot address";
            case (m_ph)
                1: begin e_req = 1'b1; e_addr = m_slot(); end
                2: begin e_req = 1'b1; e_addr = m_slot() + 32'h4; end
                3: begin e_req = 1'b1; e_addr = m_slot() + 32'h8; end
                5: begin e_req = 1'b1; e_addr = m_sa; atag = "R4 source item address"; end
                6: begin e_req = 1'b1; e_we = 1'b1; e_addr = m_da; e_wd = m_dat;
                         atag = "R4 destination item address"; end
                7: begin
                    e_req = 1'b1; e_we = 1'b1; e_addr = m_slot() + 32'h8;
                    if (m_ctl[13:4] == 10'd0) begin
                        e_wd = {m_ctl[31:14], 10'd0, m_ctl[3:2], 2'b00};
                        e_done[m_ch] = 1'b1;
                    end else begin
                        e_wd = {m_ctl[31:14], m_ctl[13:4] - 10'd1, m_ctl[3:0]};
                    end
                end
                default: ;
            endcase
            chk("R9 mem_req", 32'(mem_req), 32'(e_req));
            if (e_req) begin
                chk("R6 mem_we", 32'(mem_we), 32'(e_we));
                chk(atag, mem_addr, e_addr);
            end
            if (e_we) chk(m_ph == 6 ? "R5 moved word" : "R6 control write-back", mem_wdata, e_wd);
            chk("R11 done", 32'(done), 32'(e_done));
            if (mem_req) req_cycles++;
            if (done != '0 && first_done < 0)
                for (int k = 0; k < NCH; k++) if (done[k]) first_done = k;
            if (done[7]) done7_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_slot(input logic [31:0] at, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] c);
        mem[at] = s; mem[at + 4] = d; mem[at + 8] = c; mem[at + 12] = 32'hDEAD_BEEF;
    endtask

    task automatic run(input logic [NCH-1:0] bits, input int wait_ch);
        int n;
        n = 0;
        @(negedge clk);
        dreq = bits;
        while (!done[wait_ch] && n < 600) begin
            @(negedge clk);
            n++;
        end
        dreq = '0;
        if (n >= 600) chk("R11 completion reached", 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    localparam logic [31:0] BASE = 32'h0001_0400;

    initial begin
        logic [31:0] v;
        int rc;
        repeat (4) @(negedge clk);
        // R13 reset state
        rreg(2'd0, v); chk("R13 base after reset", v, 32'h0);
        rreg(2'd1, v); chk("R13 enables after reset", v, 32'h0);
        rreg(2'd3, v); chk("R13 half select after reset", v, 32'h0);
        chk("R13 no access in reset", 32'(mem_req), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 base alignment
        wreg(2'd0, 32'h0001_07FF);
        rreg(2'd0, v); chk("R1 base low bits zero", v, BASE);

        // R7 set/clear semantics
        wreg(2'd1, 32'h0000_0081);
        rreg(2'd1, v); chk("R7 enable set", v, 32'h81);
        wreg(2'd1, 32'h0);
        rreg(2'd1, v); chk("R7 zero set no effect", v, 32'h81);
        wreg(2'd2, 32'h0);
        rreg(2'd2, v); chk("R7 zero clear no effect", v, 32'h81);
        wreg(2'd2, 32'h0000_0081);
        rreg(2'd2, v); chk("R7 enable clear", v, 32'h0);

        // R2 R4 R5 R6 R8: four words, word steps, ch2
        for (int i = 0; i < 4; i++) mem[32'h2000 + 4 * i] = 32'hA000_0000 + i;
        put_slot(BASE + 32'h20, 32'h200C, 32'h300C,
                 (32'd2 << 30) | (32'd2 << 24) | (32'd3 << 4) | 32'h9);
        wreg(2'd1, 32'h04);
        run(8'h04, 2);
        for (int i = 0; i < 4; i++)
            chk("R5 word copy", rd(32'h3000 + 4 * i), 32'hA000_0000 + i);
        chk("R6 final control word", rd(BASE + 32'h28), (32'd2 << 30) | (32'd2 << 24) | 32'h8);
        chk("R6 source pointer untouched", rd(BASE + 32'h20), 32'h200C);
        chk("R6 destination pointer untouched", rd(BASE + 32'h24), 32'h300C);
        chk("R2 unused word untouched", rd(BASE + 32'h2C), 32'hDEAD_BEEF);
        rreg(2'd1, v); chk("R8 channel disabled itself", v, 32'h0);

        // R4: byte-stepping source, fixed destination, ch5
        mem[32'h4000] = 32'h11; mem[32'h4001] = 32'h22; mem[32'h4002] = 32'h33;
        put_slot(BASE + 32'h50, 32'h4002, 32'h5000, (32'd3 << 30) | (32'd2 << 4) | 32'h1);
        wreg(2'd1, 32'h20);
        run(8'h20, 5);
        chk("R4 fixed destination holds last byte item", rd(32'h5000), 32'h33);
        chk("R6 final control word fixed side", rd(BASE + 32'h58), 32'd3 << 30);

        // R9: request on disabled channel
        rc = req_cycles;
        @(negedge clk); dreq = 8'h02;
        repeat (20) @(negedge clk);
        dreq = '0;
        chk("R9 disabled request ignored", 32'(req_cycles - rc), 32'd0);

        // R10: ch3 and ch6 together
        mem[32'h6000] = 32'h0000_3333; mem[32'h6200] = 32'h0000_6666;
        put_slot(BASE + 32'h30, 32'h6000, 32'h6100, (32'd2 << 30) | (32'd2 << 24) | 32'h1);
        put_slot(BASE + 32'h60, 32'h6200, 32'h6300, (32'd2 << 30) | (32'd2 << 24) | 32'h1);
        wreg(2'd1, 32'h48);
        first_done = -1;
        run(8'h48, 6);
        chk("R10 lowest channel first", 32'(first_done), 32'd3);
        chk("R5 ch3 copy", rd(32'h6100), 32'h0000_3333);
        chk("R5 ch6 copy", rd(32'h6300), 32'h0000_6666);

        // R3: upper-half slot for ch4, halfword steps
        mem[32'h7000] = 32'hBEEF_0001; mem[32'h7002] = 32'hBEEF_0002;
        put_slot(BASE + 32'h240, 32'h7002, 32'h7102,
                 (32'd1 << 30) | (32'd1 << 24) | (32'd1 << 4) | 32'h1);
        wreg(2'd3, 32'h10);
        wreg(2'd1, 32'h10);
        run(8'h10, 4);
        chk("R3 upper slot item 0", rd(32'h7100), 32'hBEEF_0001);
        chk("R3 upper slot item 1", rd(32'h7102), 32'hBEEF_0002);
        chk("R3 upper slot control", rd(BASE + 32'h248), (32'd1 << 30) | (32'd1 << 24));

        // R12: stopped control word on ch7
        put_slot(BASE + 32'h70, 32'h8000, 32'h8100, (32'd5 << 4) | (32'd2 << 24));
        mem[32'h8000] = 32'h1234_5678;
        wreg(2'd1, 32'h80);
        @(negedge clk); dreq = 8'h80;
        repeat (15) @(negedge clk);
        dreq = '0;
        rreg(2'd1, v); chk("R12 stopped slot disables channel", v, 32'h0);
        chk("R12 no data moved", rd(32'h8100), 32'h0);
        chk("R12 no done", 32'(done7_seen), 32'd0);
        chk("R12 control untouched", rd(BASE + 32'h78), (32'd5 << 4) | (32'd2 << 24));

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule